// File: doc/BRIEF.md
# Priority Interrupt Router with Protected Delivery

This block collects event pulses from software, pins and peripherals into 32 request nodes. Each node holds a routing setup: an enable, the service provider it targets (three CPUs, ids 0 to 2, and one DMA engine, id 3), and an 8-bit priority. For every provider the router keeps picking the best pending request, packs the winner into a word, and protects that word with a single-error-correcting, double-error-detecting code across the link to the provider.

At the provider end a receiver decodes the word, corrects a single flipped bit, and confirms that the word names this provider and an enabled node. A CPU receiver then applies the acceptance rule: the request is offered only when the CPU's interrupt enable is set and the request priority is strictly above the CPU's current priority. The DMA receiver offers every request it gets, and the priority there names the DMA channel. Any uncorrectable or inconsistent word raises an alarm for that provider in place of the offer, and the node stays pending.

Each provider output is a valid/ready offer. Valid is a live offer: while ready is low the priority and node shown may change (a higher request may overtake, or a CPU may raise its current priority and withdraw the offer). A request counts as taken only in a cycle where valid and ready are both high, and that handshake clears the shown node's pending flag. The link fault input models corruption on each link so the protection can be exercised.

Top module: `irt_router`

## Requirements
- R1: After reset every node is disabled with priority 0 and provider 0, nothing is pending, and svc_valid, ecc_alarm and cfg_reject are all low.
- R2: A pulse on trig[i] sets node i pending in the next cycle whether or not the node is enabled; the flag holds until a handshake on that node clears it in the next cycle; if a pulse and a handshake hit the same node in one cycle, the node stays pending.
- R3: A configuration write (cfg_we) updates node cfg_node in the next cycle only while cfg_allow is high; a write with cfg_allow low changes no node and drives cfg_reject high for exactly the following cycle.
- R4: For each provider, the offer shows the pending, enabled node routed to it that has the highest priority; among equal priorities the lowest node index wins.
- R5: A CPU provider offers its winner only when its cpu_ie bit is 1 and the winner's priority is strictly greater than its cpu_ccpn value, so a CPU at current priority 255 and a request of priority 0 are never offered to a CPU.
- R6: The DMA provider (id 3) offers its winner regardless of the CPU controls, including priority 0, with svc_prio giving the channel.
- R7: svc_valid with svc_ready is the only acknowledge; while unacknowledged, the node stays pending.
- R8: The link word holds data bits en (bit 0), node (bits 5:1), priority (bits 13:6) and provider (bits 15:14); code position 0 is overall parity, positions 1, 2, 4, 8 and 16 are parity bits each covering the positions that have that bit set, and data bits fill the other positions 3 to 21 in ascending order from data bit 0. Any single flipped bit in link_flip leaves the offer unchanged.
- R9: Any two flipped bits on a provider's link with a request present raise ecc_alarm for that provider, drop svc_valid, and keep the node pending.
- R10: A link word that decodes cleanly but names a different provider or has the enable bit at 0 raises ecc_alarm and is not offered.
- R11: ecc_alarm is never high for a provider that has no pending enabled request routed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 32 | Per-node event pulses |
| cfg_we | input | 1 | Node configuration write strobe |
| cfg_allow | input | 1 | Write permission from the access gate |
| cfg_node | input | 5 | Node index being written |
| cfg_en | input | 1 | Enable value to write |
| cfg_prov | input | 2 | Target provider to write (0-2 CPU, 3 DMA) |
| cfg_prio | input | 8 | Priority to write |
| cfg_reject | output | 1 | One-cycle flag after a refused write |
| cpu_ie | input | 3 | Interrupt enable per CPU |
| cpu_ccpn | input | 24 | Current priority per CPU, 8 bits each |
| link_flip | input | 88 | Per-provider 22-bit link fault mask |
| svc_valid | output | 4 | Offer valid per provider |
| svc_ready | input | 4 | Offer accepted per provider |
| svc_prio | output | 32 | Offered priority or DMA channel, 8 bits per provider |
| svc_node | output | 20 | Offered node index, 5 bits per provider |
| ecc_alarm | output | 4 | Uncorrectable or inconsistent link word per provider |

## Verification
Two functions can meet on one node in one cycle: a fresh event pulse and the handshake that retires the same node. The bench drives trig on the exact node shown on an offer while svc_ready is high and then judges that the node is still offered in the next cycle, and a further handshake without a pulse empties it. The random phase also lands configuration writes on nodes that are pending or on offer, and a reference model in the bench decides every cycle which node each provider must show.

// File: rtl/irt_pkg.sv
package irt_pkg;
  parameter int NODES  = 32;
  parameter int NCPU   = 3;
  parameter int PRIO_W = 8;

  localparam int NPROV  = NCPU + 1;
  localparam int NODE_W = $clog2(NODES);
  localparam int PROV_W = $clog2(NPROV);
  localparam int DATA_W = PROV_W + PRIO_W + NODE_W + 1;

  function automatic int parity_bits(input int d);
    int r;
    r = 1;
    while ((1 << r) < d + r + 1) r++;
    return r;
  endfunction

  localparam int PAR_W  = parity_bits(DATA_W);
  localparam int CODE_W = DATA_W + PAR_W + 1;

  typedef struct packed {
    logic [PROV_W-1:0] prov;
    logic [PRIO_W-1:0] prio;
    logic [NODE_W-1:0] node;
    logic              en;
  } svc_word_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              fatal;
  } dec_t;

  function automatic logic [CODE_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int pos = 1; pos < CODE_W; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        c[pos] = d[k];
        k++;
      end
    end
    for (int b = 0; b < PAR_W; b++) begin
      for (int pos = 1; pos < CODE_W; pos++) begin
        if (((pos >> b) & 1) == 1 && pos != (1 << b)) c[1 << b] = c[1 << b] ^ c[pos];
      end
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic dec_t secded_dec(input logic [CODE_W-1:0] c);
    logic [PAR_W-1:0]  syn;
    logic [CODE_W-1:0] fixed;
    logic              ovr;
    dec_t              r;
    int                k;
    syn = '0;
    for (int b = 0; b < PAR_W; b++) begin
      for (int pos = 1; pos < CODE_W; pos++) begin
        if (((pos >> b) & 1) == 1) syn[b] = syn[b] ^ c[pos];
      end
    end
    ovr   = ^c;
    fixed = c;
    r     = '0;
    if (ovr) begin
      if (int'(syn) < CODE_W) fixed[syn] = ~fixed[syn];
      else r.fatal = 1'b1;
    end else if (syn != '0) begin
      r.fatal = 1'b1;
    end
    k = 0;
    for (int pos = 1; pos < CODE_W; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        r.data[k] = fixed[pos];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irt_node_bank.sv
module irt_node_bank
  import irt_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NODES-1:0]                  trig,
  input  logic                              cfg_we,
  input  logic                              cfg_allow,
  input  logic [NODE_W-1:0]                 cfg_node,
  input  logic                              cfg_en,
  input  logic [PROV_W-1:0]                 cfg_prov,
  input  logic [PRIO_W-1:0]                 cfg_prio,
  output logic                              cfg_reject,
  input  logic [NPROV-1:0]                  ack_vld,
  input  logic [NPROV-1:0][NODE_W-1:0]      ack_node,
  output logic [NODES-1:0]                  node_en,
  output logic [NODES-1:0][PROV_W-1:0]      node_prov,
  output logic [NODES-1:0][PRIO_W-1:0]      node_prio,
  output logic [NODES-1:0]                  pending
);
  logic [NODES-1:0] clr;
  logic             wr_ok;

  assign wr_ok = cfg_we && cfg_allow;

  always_comb begin
    clr = '0;
    for (int p = 0; p < NPROV; p++) begin
      if (ack_vld[p]) clr[ack_node[p]] = 1'b1;
    end
  end

  // a new pulse wins over a retiring handshake on the same node
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= '0;
      cfg_reject <= 1'b0;
    end else begin
      pending    <= (pending & ~clr) | trig;
      cfg_reject <= cfg_we && !cfg_allow;
    end
  end

  for (genvar i = 0; i < NODES; i++) begin : g_node
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        node_en[i]   <= 1'b0;
        node_prov[i] <= '0;
        node_prio[i] <= '0;
      end else if (wr_ok && cfg_node == NODE_W'(i)) begin
        node_en[i]   <= cfg_en;
        node_prov[i] <= cfg_prov;
        node_prio[i] <= cfg_prio;
      end
    end
  end

  assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |=> ((pending & $past(trig)) == $past(trig)));

  assert_reject_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_allow) |=> cfg_reject);

  assert_denied_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_allow) |=> ($stable(node_en) && $stable(node_prov) && $stable(node_prio)));
endmodule

// File: rtl/irt_arbiter.sv
module irt_arbiter
  import irt_pkg::*;
#(
  parameter int PID = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NODES-1:0]             node_en,
  input  logic [NODES-1:0][PROV_W-1:0] node_prov,
  input  logic [NODES-1:0][PRIO_W-1:0] node_prio,
  input  logic [NODES-1:0]             pending,
  output logic                         req,
  output logic [NODE_W-1:0]            win_node,
  output logic [PRIO_W-1:0]            win_prio,
  output logic                         win_en
);
  // strict compare in ascending scan keeps the lowest index on ties
  always_comb begin
    req      = 1'b0;
    win_node = '0;
    win_prio = '0;
    for (int i = 0; i < NODES; i++) begin
      if (pending[i] && node_en[i] && node_prov[i] == PROV_W'(PID) &&
          (!req || node_prio[i] > win_prio)) begin
        req      = 1'b1;
        win_node = NODE_W'(i);
        win_prio = node_prio[i];
      end
    end
  end

  assign win_en = req && node_en[win_node];

  assert_win_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (pending[win_node] && node_en[win_node] && node_prov[win_node] == PROV_W'(PID)));
endmodule

// File: rtl/irt_svc_rx.sv
module irt_svc_rx
  import irt_pkg::*;
#(
  parameter int PID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CODE_W-1:0] code,
  input  logic              ie,
  input  logic [PRIO_W-1:0] ccpn,
  input  logic              svc_ready,
  output logic              svc_valid,
  output logic [PRIO_W-1:0] svc_prio,
  output logic [NODE_W-1:0] svc_node,
  output logic              alarm,
  output logic              ack
);
  localparam bit IS_CPU = (PID < NCPU);

  dec_t      dec;
  svc_word_t w;
  logic      sound;
  logic      accept;

  assign dec    = secded_dec(code);
  assign w      = svc_word_t'(dec.data);
  assign sound  = !dec.fatal && w.en && (w.prov == PROV_W'(PID));
  assign accept = IS_CPU ? (ie && (w.prio > ccpn)) : 1'b1;

  assign alarm     = req && !sound;
  assign svc_valid = req && sound && accept;
  assign svc_prio  = w.prio;
  assign svc_node  = w.node;
  assign ack       = svc_valid && svc_ready;

  assert_cpu_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (!IS_CPU || (ie && svc_prio > ccpn)));

  assert_alarm_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> !svc_valid);

  assert_alarm_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !alarm);
endmodule

// File: rtl/irt_router.sv
module irt_router
  import irt_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NODES-1:0]          trig,
  input  logic                      cfg_we,
  input  logic                      cfg_allow,
  input  logic [NODE_W-1:0]         cfg_node,
  input  logic                      cfg_en,
  input  logic [PROV_W-1:0]         cfg_prov,
  input  logic [PRIO_W-1:0]         cfg_prio,
  output logic                      cfg_reject,
  input  logic [NCPU-1:0]           cpu_ie,
  input  logic [NCPU*PRIO_W-1:0]    cpu_ccpn,
  input  logic [NPROV*CODE_W-1:0]   link_flip,
  output logic [NPROV-1:0]          svc_valid,
  input  logic [NPROV-1:0]          svc_ready,
  output logic [NPROV*PRIO_W-1:0]   svc_prio,
  output logic [NPROV*NODE_W-1:0]   svc_node,
  output logic [NPROV-1:0]          ecc_alarm
);
  logic [NODES-1:0]             node_en;
  logic [NODES-1:0][PROV_W-1:0] node_prov;
  logic [NODES-1:0][PRIO_W-1:0] node_prio;
  logic [NODES-1:0]             pending;
  logic [NPROV-1:0]             ack_vld;
  logic [NPROV-1:0][NODE_W-1:0] ack_node;

  irt_node_bank u_bank (
    .clk(clk), .rst_n(rst_n), .trig(trig),
    .cfg_we(cfg_we), .cfg_allow(cfg_allow), .cfg_node(cfg_node),
    .cfg_en(cfg_en), .cfg_prov(cfg_prov), .cfg_prio(cfg_prio),
    .cfg_reject(cfg_reject), .ack_vld(ack_vld), .ack_node(ack_node),
    .node_en(node_en), .node_prov(node_prov), .node_prio(node_prio),
    .pending(pending)
  );

  for (genvar g = 0; g < NPROV; g++) begin : g_prov
    logic              req;
    logic [NODE_W-1:0] win_node;
    logic [PRIO_W-1:0] win_prio;
    logic              win_en;
    svc_word_t         word;
    logic [CODE_W-1:0] code_tx;
    logic [CODE_W-1:0] code_rx;
    logic              ie_p;
    logic [PRIO_W-1:0] ccpn_p;

    if (g < NCPU) begin : g_cpu
      assign ie_p   = cpu_ie[g];
      assign ccpn_p = cpu_ccpn[g*PRIO_W +: PRIO_W];
    end else begin : g_dma
      assign ie_p   = 1'b1;
      assign ccpn_p = '0;
    end

    irt_arbiter #(.PID(g)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .node_en(node_en), .node_prov(node_prov), .node_prio(node_prio),
      .pending(pending), .req(req), .win_node(win_node),
      .win_prio(win_prio), .win_en(win_en)
    );

    assign word    = '{prov: PROV_W'(g), prio: win_prio, node: win_node, en: win_en};
    assign code_tx = secded_enc(DATA_W'(word));
    assign code_rx = code_tx ^ link_flip[g*CODE_W +: CODE_W];

    irt_svc_rx #(.PID(g)) u_rx (
      .clk(clk), .rst_n(rst_n), .req(req), .code(code_rx),
      .ie(ie_p), .ccpn(ccpn_p), .svc_ready(svc_ready[g]),
      .svc_valid(svc_valid[g]), .svc_prio(svc_prio[g*PRIO_W +: PRIO_W]),
      .svc_node(svc_node[g*NODE_W +: NODE_W]), .alarm(ecc_alarm[g]),
      .ack(ack_vld[g])
    );

    assign ack_node[g] = svc_node[g*NODE_W +: NODE_W];

    assert_offer_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      svc_valid[g] |-> pending[svc_node[g*NODE_W +: NODE_W]]);

    assert_held_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_valid[g] && !svc_ready[g]) |=> pending[$past(svc_node[g*NODE_W +: NODE_W])]);
  end
endmodule

// File: tb/tb_irt_router.sv
`timescale 1ns/1ps
module tb_irt_router;
  import irt_pkg::*;

  localparam time CLK_P = 20ns;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [NODES-1:0]        trig;
  logic                    cfg_we, cfg_allow, cfg_en;
  logic [NODE_W-1:0]       cfg_node;
  logic [PROV_W-1:0]       cfg_prov;
  logic [PRIO_W-1:0]       cfg_prio;
  logic                    cfg_reject;
  logic [NCPU-1:0]         cpu_ie;
  logic [NCPU*PRIO_W-1:0]  cpu_ccpn;
  logic [NPROV*CODE_W-1:0] link_flip;
  logic [NPROV-1:0]        svc_valid, svc_ready, ecc_alarm;
  logic [NPROV*PRIO_W-1:0] svc_prio;
  logic [NPROV*NODE_W-1:0] svc_node;

  always #(CLK_P/2) clk = ~clk;

  irt_router dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_we(cfg_we), .cfg_allow(cfg_allow),
    .cfg_node(cfg_node), .cfg_en(cfg_en), .cfg_prov(cfg_prov), .cfg_prio(cfg_prio),
    .cfg_reject(cfg_reject), .cpu_ie(cpu_ie), .cpu_ccpn(cpu_ccpn), .link_flip(link_flip),
    .svc_valid(svc_valid), .svc_ready(svc_ready), .svc_prio(svc_prio),
    .svc_node(svc_node), .ecc_alarm(ecc_alarm)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  bit               m_en   [NODES];
  int               m_prov [NODES];
  int               m_prio [NODES];
  logic [NODES-1:0] m_pend;
  bit               mis    [NPROV];
  bit               exp_rej;

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int prio_of(input int p);
    return int'(svc_prio[p*PRIO_W +: PRIO_W]);
  endfunction
  function automatic int node_of(input int p);
    return int'(svc_node[p*NODE_W +: NODE_W]);
  endfunction

  function automatic void pick(input int p, output bit f, output int n, output int pr);
    f = 0; n = 0; pr = 0;
    for (int i = 0; i < NODES; i++) begin
      if (m_pend[i] && m_en[i] && m_prov[i] == p && (!f || m_prio[i] > pr)) begin
        f = 1; n = i; pr = m_prio[i];
      end
    end
  endfunction

  function automatic logic [CODE_W-1:0] tb_enc(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int k;
    c = '0; k = 0;
    for (int pos = 3; pos < CODE_W; pos++) begin
      if ($countones(pos) != 1) begin c[pos] = d[k]; k++; end
    end
    for (int b = 0; b < PAR_W; b++) begin
      for (int pos = 1; pos < CODE_W; pos++) begin
        if (((pos >> b) & 1) == 1 && pos != (1 << b)) c[1 << b] ^= c[pos];
      end
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  // compare all outputs against the model, then advance the model one edge
  task automatic tick();
    bit f, acc, ev, ea;
    int n, pr, nf;
    logic [NODES-1:0] clr;
    #2;
    clr = '0;
    cmp("R3 reject flag", int'(cfg_reject), int'(exp_rej));
    for (int p = 0; p < NPROV; p++) begin
      pick(p, f, n, pr);
      nf  = $countones(link_flip[p*CODE_W +: CODE_W]);
      acc = (p < NCPU) ? (cpu_ie[p] && pr > int'(cpu_ccpn[p*PRIO_W +: PRIO_W])) : 1'b1;
      ea  = f && (nf == 2 || mis[p]);
      ev  = f && !ea && acc;
      cmp("R9 alarm", int'(ecc_alarm[p]), int'(ea));
      cmp("R4 valid", int'(svc_valid[p]), int'(ev));
      if (ev) begin
        cmp("R4 node", node_of(p), n);
        cmp("R4 prio", prio_of(p), pr);
        if (svc_ready[p]) clr[n] = 1'b1;
      end
    end
    exp_rej = cfg_we && !cfg_allow;
    m_pend = (m_pend & ~clr) | trig;
    if (cfg_we && cfg_allow) begin
      m_en[cfg_node] = cfg_en;
      m_prov[cfg_node] = int'(cfg_prov);
      m_prio[cfg_node] = int'(cfg_prio);
    end
    @(negedge clk);
  endtask

  task automatic wr(input int node, input int prov, input int prio, input bit en, input bit allow);
    cfg_we = 1; cfg_allow = allow; cfg_node = NODE_W'(node);
    cfg_prov = PROV_W'(prov); cfg_prio = PRIO_W'(prio); cfg_en = en;
    tick();
    cfg_we = 0; cfg_allow = 0;
  endtask

  task automatic pulse(input logic [NODES-1:0] m);
    trig = m;
    tick();
    trig = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5a));
    rst_n = 0; trig = '0; cfg_we = 0; cfg_allow = 0; cfg_node = '0; cfg_en = 0;
    cfg_prov = '0; cfg_prio = '0; cpu_ie = '1; cpu_ccpn = '0; link_flip = '0; svc_ready = '0;
    m_pend = '0; exp_rej = 0;
    for (int i = 0; i < NODES; i++) begin m_en[i] = 0; m_prov[i] = 0; m_prio[i] = 0; end
    for (int p = 0; p < NPROV; p++) mis[p] = 0;
    repeat (3) @(negedge clk);
    #1;
    cmp("R1 valid in reset", int'(svc_valid), 0);
    cmp("R1 alarm in reset", int'(ecc_alarm), 0);
    cmp("R1 reject in reset", int'(cfg_reject), 0);
    rst_n = 1;
    @(negedge clk);

    // R4 tie on equal priority
    wr(4, 0, 50, 1, 1);
    wr(9, 0, 50, 1, 1);
    pulse((NODES'(1) << 4) | (NODES'(1) << 9));
    #1 cmp("R4 tie valid", int'(svc_valid[0]), 1);
    cmp("R4 tie lowest index", node_of(0), 4);
    svc_ready[0] = 1; tick(); svc_ready[0] = 0;
    #1 cmp("R2 after ack next node", node_of(0), 9);
    // R2 pulse and handshake on the same node
    svc_ready[0] = 1; trig = NODES'(1) << 9; tick(); trig = '0; svc_ready[0] = 0;
    #1 cmp("R2 same-cycle pulse keeps pending", int'(svc_valid[0]), 1);
    cmp("R2 same-cycle node", node_of(0), 9);
    svc_ready[0] = 1; tick(); svc_ready[0] = 0;
    #1 cmp("R2 cleared by handshake", int'(svc_valid[0]), 0);

    // R5 acceptance
    wr(4, 0, 255, 1, 1);
    pulse(NODES'(1) << 4);
    cpu_ccpn[7:0] = 8'd255;
    #1 cmp("R5 ccpn 255 blocks", int'(svc_valid[0]), 0);
    tick();
    cpu_ccpn[7:0] = 8'd254;
    #1 cmp("R5 prio above ccpn", int'(svc_valid[0]), 1);
    tick();
    cpu_ie[0] = 0;
    #1 cmp("R5 ie low blocks", int'(svc_valid[0]), 0);
    tick();
    cpu_ie[0] = 1; cpu_ccpn[7:0] = 8'd0; svc_ready[0] = 1; tick(); svc_ready[0] = 0;

    // R5 / R6 priority zero
    wr(7, 0, 0, 1, 1);
    wr(8, 3, 0, 1, 1);
    pulse((NODES'(1) << 7) | (NODES'(1) << 8));
    #1 cmp("R5 prio 0 never to CPU", int'(svc_valid[0]), 0);
    cmp("R6 prio 0 to DMA", int'(svc_valid[3]), 1);
    cmp("R6 DMA channel", prio_of(3), 0);
    cmp("R6 DMA node", node_of(3), 8);
    svc_ready[3] = 1; tick(); svc_ready[3] = 0;

    // R3 refused write
    wr(10, 1, 9, 1, 0);
    #1 cmp("R3 reject raised", int'(cfg_reject), 1);
    pulse(NODES'(1) << 10);
    #1 cmp("R3 refused write had no effect", int'(svc_valid[1]), 0);

    // R8 single-bit correction on every position
    wr(12, 2, 77, 1, 1);
    pulse(NODES'(1) << 12);
    for (int pos = 0; pos < CODE_W; pos++) begin
      link_flip = '0;
      link_flip[2*CODE_W + pos] = 1'b1;
      #1 cmp("R8 corrected valid", int'(svc_valid[2]), 1);
      cmp("R8 corrected prio", prio_of(2), 77);
      cmp("R8 corrected node", node_of(2), 12);
      tick();
    end
    link_flip = '0;

    // R9 double error
    link_flip[2*CODE_W + 3] = 1'b1; link_flip[2*CODE_W + 10] = 1'b1;
    #1 cmp("R9 alarm on double", int'(ecc_alarm[2]), 1);
    cmp("R9 no offer on double", int'(svc_valid[2]), 0);
    svc_ready[2] = 1; tick(); svc_ready[2] = 0;
    link_flip = '0;
    #1 cmp("R9 node kept pending", int'(svc_valid[2]), 1);

    // R10 clean word for the wrong provider, then with enable cleared
    link_flip[2*CODE_W +: CODE_W] = tb_enc({2'd2, 8'd77, 5'd12, 1'b1}) ^ tb_enc({2'd1, 8'd77, 5'd12, 1'b1});
    mis[2] = 1;
    #1 cmp("R10 wrong provider alarm", int'(ecc_alarm[2]), 1);
    tick();
    link_flip[2*CODE_W +: CODE_W] = tb_enc({2'd2, 8'd77, 5'd12, 1'b1}) ^ tb_enc({2'd2, 8'd77, 5'd12, 1'b0});
    #1 cmp("R10 enable clear alarm", int'(ecc_alarm[2]), 1);
    cmp("R10 enable clear no offer", int'(svc_valid[2]), 0);
    tick();
    mis[2] = 0; link_flip = '0;

    // R11 no request, no alarm
    link_flip[1*CODE_W + 2] = 1'b1; link_flip[1*CODE_W + 15] = 1'b1;
    #1 cmp("R11 idle link quiet", int'(ecc_alarm[1]), 0);
    tick();
    link_flip = '0;
    svc_ready[2] = 1; tick(); svc_ready[2] = 0;

    // constrained random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      trig = NODES'($urandom & $urandom & $urandom & $urandom);
      cfg_we = ($urandom % 4) == 0;
      cfg_allow = ($urandom % 4) != 0;
      cfg_node = NODE_W'($urandom);
      cfg_prov = PROV_W'($urandom);
      case ($urandom % 6)
        0: cfg_prio = 8'd0;
        1: cfg_prio = 8'd255;
        default: cfg_prio = PRIO_W'($urandom);
      endcase
      cfg_en = ($urandom % 8) != 0;
      for (int c = 0; c < NCPU; c++) begin
        cpu_ie[c] = ($urandom % 8) != 0;
        case ($urandom % 8)
          0: cpu_ccpn[c*PRIO_W +: PRIO_W] = 8'd255;
          1: cpu_ccpn[c*PRIO_W +: PRIO_W] = 8'd0;
          default: cpu_ccpn[c*PRIO_W +: PRIO_W] = PRIO_W'($urandom % 160);
        endcase
      end
      svc_ready = NPROV'($urandom);
      link_flip = '0;
      case ($urandom % 16)
        0, 1: link_flip[($urandom % NPROV) * CODE_W + ($urandom % CODE_W)] = 1'b1;
        2: begin
          int p, a, b;
          p = $urandom % NPROV;
          a = $urandom % CODE_W;
          b = (a + 1 + ($urandom % (CODE_W - 1))) % CODE_W;
          link_flip[p*CODE_W + a] = 1'b1;
          link_flip[p*CODE_W + b] = 1'b1;
        end
        default: ;
      endcase
      tick();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule